// File: doc/BRIEF.md
# Triggered Working-Register Data Unit

This block holds one working register and applies to it one of several operations picked by a static operation code: counting that stops at a bound, counting that wraps, bidirectional counting, right rotation, serial right shift, a bitwise compare against a constant, or a shift with a three-bit majority detector. Three active-high trigger inputs drive the operation. The first trigger always reloads the register from a load constant. The other two triggers enable stepping, set the count direction, or supply the serial data bit, depending on the operation.

The block produces one output bit. Each operation computes this bit from the register in its own way: a level when the register matches a bound, a single-cycle pulse when a wrapping counter steps onto its bound, the register's least significant bit, a compare result, or a majority detect. Surrounding logic picks the trigger sources. The operation code and the two constants are expected to change only while the block is held in reset.

Top module: `du_top`

## Requirements
- R1: When trig0 is high at a clock edge, the register takes load_val, whatever the operation and whatever trig1 and trig2 are doing.
- R2: op_sel 0 (count up, one-shot): trig1 adds one per cycle until the register equals limit_val, then the register holds. unit_out is high while the register equals limit_val.
- R3: op_sel 1 (count down, one-shot): trig1 subtracts one per cycle until the register is 0, then the register holds. unit_out is high while the register is 0.
- R4: op_sel 2 (count up, wrapping): with trig1 high, the register steps up, and a step taken from limit_val reloads load_val. unit_out is high for exactly one cycle after a step lands on limit_val.
- R5: op_sel 3 (count down, wrapping): with trig1 high, the register steps down, and a step taken from 0 reloads load_val. unit_out is high for exactly one cycle after a step lands on 0.
- R6: op_sel 4 (up/down, clamped): trig1 alone counts up but not past limit_val, trig2 alone counts down but not below 0, and both high together hold the register. unit_out is high while the register equals limit_val or 0.
- R7: op_sel 5 (up/down, wrapping): as R6, except that an up step from limit_val and a down step from 0 both reload load_val.
- R8: op_sel 6 (rotate right): trig1 rotates the register right by one, bit 0 moving into the top bit. unit_out is bit 0.
- R9: op_sel 7 (shift right): trig1 shifts the register right by one and trig2 enters the top bit. unit_out is bit 0.
- R10: op_sel 8 makes unit_out the OR-reduce of (register AND limit_val). op_sel 9 makes it the OR-reduce of (register OR limit_val). Only trig0 changes the register in these two operations.
- R11: op_sel 10 shifts as in R9. unit_out is high when the register value is 3, 5, 6 or 7.
- R12: Reset sets the register to 0 and clears the step flag. Codes 11 to 15 leave the register unchanged except by trig0, and hold unit_out at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 4 | Operation code, static outside reset |
| trig0 | input | 1 | Reload trigger |
| trig1 | input | 1 | Step / up / shift-enable trigger |
| trig2 | input | 1 | Down trigger or serial data bit |
| load_val | input | DW | Constant loaded by trig0 and on wrap |
| limit_val | input | DW | Upper bound or compare constant |
| unit_out | output | 1 | Single-bit result |

## Verification
The assertions check the following on every cycle: the reload priority, the hold at the one-shot bounds, the hold when both directions are requested, the pulse width in the wrapping up-counter, the preservation of the set-bit count under rotation, the top bit entered by a shift, and the silent output for unused codes. The bench's scenarios are needed for the rest. They follow whole count sequences through their wrap points. They show that the bounded counters stay at their bound and that the compare results are correct. They also run the majority detector over a real shifted bit stream. A behavioural model in the bench follows every one of these sequences and checks the output on every clock.

// File: rtl/du_pkg.sv
package du_pkg;

  typedef enum logic [3:0] {
    OP_INC       = 4'd0,
    OP_DEC       = 4'd1,
    OP_INC_WRAP  = 4'd2,
    OP_DEC_WRAP  = 4'd3,
    OP_UPDN      = 4'd4,
    OP_UPDN_WRAP = 4'd5,
    OP_ROR       = 4'd6,
    OP_SHR       = 4'd7,
    OP_AND       = 4'd8,
    OP_OR        = 4'd9,
    OP_SHR_MAJ   = 4'd10
  } du_op_e;

  localparam int unsigned OP_LAST = 10;

  // true when the operation uses the step flag for a pulse output
  function automatic logic op_pulses(du_op_e op);
    return (op == OP_INC_WRAP) || (op == OP_DEC_WRAP);
  endfunction

  // true when the code is a defined operation
  function automatic logic op_known(logic [3:0] code);
    return 32'(code) <= OP_LAST;
  endfunction

endpackage

// File: rtl/du_next.sv
module du_next
  import du_pkg::*;
#(
  parameter int DW = 8
) (
  input  du_op_e          op,
  input  logic            trig0,
  input  logic            trig1,
  input  logic            trig2,
  input  logic [DW-1:0]   work_q,
  input  logic [DW-1:0]   load_val,
  input  logic            at_lim,
  input  logic            at_zero,
  output logic [DW-1:0]   work_nxt,
  output logic            step_en
);

  function automatic logic [DW-1:0] up1(logic [DW-1:0] v);
    return v + 1'b1;
  endfunction

  function automatic logic [DW-1:0] dn1(logic [DW-1:0] v);
    return v - 1'b1;
  endfunction

  function automatic logic [DW-1:0] ror1(logic [DW-1:0] v);
    return {v[0], v[DW-1:1]};
  endfunction

  function automatic logic [DW-1:0] shr1(logic [DW-1:0] v, logic din);
    return {din, v[DW-1:1]};
  endfunction

  logic up_req;
  logic dn_req;

  assign up_req = trig1 & ~trig2;
  assign dn_req = trig2 & ~trig1;

  always_comb begin
    work_nxt = work_q;
    step_en  = 1'b0;
    if (trig0) begin
      work_nxt = load_val;
    end else begin
      case (op)
        OP_INC: if (trig1 && !at_lim) begin
          work_nxt = up1(work_q);
          step_en  = 1'b1;
        end
        OP_DEC: if (trig1 && !at_zero) begin
          work_nxt = dn1(work_q);
          step_en  = 1'b1;
        end
        OP_INC_WRAP: if (trig1) begin
          work_nxt = at_lim ? load_val : up1(work_q);
          step_en  = 1'b1;
        end
        OP_DEC_WRAP: if (trig1) begin
          work_nxt = at_zero ? load_val : dn1(work_q);
          step_en  = 1'b1;
        end
        OP_UPDN: begin
          if (up_req && !at_lim) begin
            work_nxt = up1(work_q);
            step_en  = 1'b1;
          end else if (dn_req && !at_zero) begin
            work_nxt = dn1(work_q);
            step_en  = 1'b1;
          end
        end
        OP_UPDN_WRAP: begin
          if (up_req) begin
            work_nxt = at_lim ? load_val : up1(work_q);
            step_en  = 1'b1;
          end else if (dn_req) begin
            work_nxt = at_zero ? load_val : dn1(work_q);
            step_en  = 1'b1;
          end
        end
        OP_ROR: if (trig1) begin
          work_nxt = ror1(work_q);
          step_en  = 1'b1;
        end
        OP_SHR, OP_SHR_MAJ: if (trig1) begin
          work_nxt = shr1(work_q, trig2);
          step_en  = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/du_state.sv
module du_state #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] work_nxt,
  input  logic          step_en,
  output logic [DW-1:0] work_q,
  output logic          fresh_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q  <= '0;
      fresh_q <= 1'b0;
    end else begin
      work_q  <= work_nxt;
      fresh_q <= step_en;
    end
  end

endmodule

// File: rtl/du_decode.sv
module du_decode
  import du_pkg::*;
#(
  parameter int DW = 8
) (
  input  du_op_e        op,
  input  logic [3:0]    op_code,
  input  logic [DW-1:0] work_q,
  input  logic [DW-1:0] limit_val,
  input  logic          fresh_q,
  input  logic          at_lim,
  input  logic          at_zero,
  output logic          res
);

  localparam int HI = DW - 3;

  function automatic logic maj3(logic [DW-1:0] v);
    logic [1:0] cnt;
    cnt = {1'b0, v[0]} + {1'b0, v[1]} + {1'b0, v[2]};
    return (cnt >= 2'd2) && ((v >> 3) == '0);
  endfunction

  logic maj_hit;

  generate
    if (HI > 0) begin : g_wide
      assign maj_hit = maj3(work_q);
    end else begin : g_narrow
      assign maj_hit = (work_q[0] & work_q[1]) | (work_q[0] & work_q[2]) |
                       (work_q[1] & work_q[2]);
    end
  endgenerate

  logic pulse_ok;
  assign pulse_ok = fresh_q & op_pulses(op);

  always_comb begin
    res = 1'b0;
    if (op_known(op_code)) begin
      case (op)
        OP_INC:       res = at_lim;
        OP_DEC:       res = at_zero;
        OP_INC_WRAP:  res = pulse_ok & at_lim;
        OP_DEC_WRAP:  res = pulse_ok & at_zero;
        OP_UPDN,
        OP_UPDN_WRAP: res = at_lim | at_zero;
        OP_ROR,
        OP_SHR:       res = work_q[0];
        OP_AND:       res = |(work_q & limit_val);
        OP_OR:        res = |(work_q | limit_val);
        OP_SHR_MAJ:   res = maj_hit;
        default:      res = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/du_top.sv
module du_top
  import du_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    op_sel,
  input  logic          trig0,
  input  logic          trig1,
  input  logic          trig2,
  input  logic [DW-1:0] load_val,
  input  logic [DW-1:0] limit_val,
  output logic          unit_out
);

  du_op_e        op;
  logic [DW-1:0] work_q;
  logic [DW-1:0] work_nxt;
  logic          fresh_q;
  logic          step_en;
  logic          at_lim;
  logic          at_zero;

  assign op      = du_op_e'(op_sel);
  assign at_lim  = (work_q == limit_val);
  assign at_zero = (work_q == '0);

  du_next #(.DW(DW)) u_next (
    .op       (op),
    .trig0    (trig0),
    .trig1    (trig1),
    .trig2    (trig2),
    .work_q   (work_q),
    .load_val (load_val),
    .at_lim   (at_lim),
    .at_zero  (at_zero),
    .work_nxt (work_nxt),
    .step_en  (step_en)
  );

  du_state #(.DW(DW)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .work_nxt (work_nxt),
    .step_en  (step_en),
    .work_q   (work_q),
    .fresh_q  (fresh_q)
  );

  du_decode #(.DW(DW)) u_decode (
    .op        (op),
    .op_code   (op_sel),
    .work_q    (work_q),
    .limit_val (limit_val),
    .fresh_q   (fresh_q),
    .at_lim    (at_lim),
    .at_zero   (at_zero),
    .res       (unit_out)
  );

endmodule

// File: rtl/du_chk.sv
module du_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    op_sel,
  input logic          trig0,
  input logic          trig1,
  input logic          trig2,
  input logic [DW-1:0] load_val,
  input logic [DW-1:0] limit_val,
  input logic [DW-1:0] work_q,
  input logic          unit_out
);

  // R1
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig0 |=> work_q == $past(load_val));

  // R2
  inc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd0 && !trig0 && work_q == limit_val) |=> work_q == $past(work_q));

  // R3
  dec_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd1 && !trig0 && work_q == '0) |=> work_q == $past(work_q));

  // R4
  wrap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd2 && unit_out && load_val != limit_val) |=> !unit_out);

  // R6
  both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_sel == 4'd4 || op_sel == 4'd5) && trig1 && trig2 && !trig0) |=> $stable(work_q));

  // R8
  ror_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd6 && trig1 && !trig0) |=> $countones(work_q) == $countones($past(work_q)));

  // R9
  shr_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_sel == 4'd7 || op_sel == 4'd10) && trig1 && !trig0) |=> work_q[DW-1] == $past(trig2));

  // R12
  unused_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > 4'd10) |-> !unit_out);

endmodule

bind du_top du_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_sel    (op_sel),
  .trig0     (trig0),
  .trig1     (trig1),
  .trig2     (trig2),
  .load_val  (load_val),
  .limit_val (limit_val),
  .work_q    (work_q),
  .unit_out  (unit_out)
);

// File: tb/du_top_tb.sv
module du_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    op_sel = 4'd0;
  logic          trig0 = 1'b0;
  logic          trig1 = 1'b0;
  logic          trig2 = 1'b0;
  logic [DW-1:0] load_val = '0;
  logic [DW-1:0] limit_val = '0;
  logic          unit_out;

  int errors = 0;
  int checks = 0;
  string tag = "R12";
  bit finished = 1'b0;

  int m_w;
  bit m_f;
  int m_op, m_d0, m_d1;

  always #(CLK_PERIOD/2) clk = ~clk;

  du_top #(.DW(DW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_sel    (op_sel),
    .trig0     (trig0),
    .trig1     (trig1),
    .trig2     (trig2),
    .load_val  (load_val),
    .limit_val (limit_val),
    .unit_out  (unit_out)
  );

  function automatic bit model_out();
    case (m_op)
      0: return m_w == m_d1;
      1: return m_w == 0;
      2: return m_f && m_w == m_d1;
      3: return m_f && m_w == 0;
      4, 5: return (m_w == m_d1) || (m_w == 0);
      6, 7: return (m_w % 2) == 1;
      8: return (m_w & m_d1) != 0;
      9: return (m_w | m_d1) != 0;
      10: return m_w == 3 || m_w == 5 || m_w == 6 || m_w == 7;
      default: return 1'b0;
    endcase
  endfunction

  function automatic void model_step(bit t0, bit t1, bit t2);
    bit nf = 1'b0;
    if (t0) begin
      m_w = m_d0;
    end else begin
      case (m_op)
        0: if (t1 && m_w != m_d1) m_w = (m_w + 1) % 256;
        1: if (t1 && m_w != 0) m_w = m_w - 1;
        2: if (t1) begin m_w = (m_w == m_d1) ? m_d0 : (m_w + 1) % 256; nf = 1'b1; end
        3: if (t1) begin m_w = (m_w == 0) ? m_d0 : m_w - 1; nf = 1'b1; end
        4: begin
          if (t1 && !t2 && m_w != m_d1) m_w = (m_w + 1) % 256;
          else if (t2 && !t1 && m_w != 0) m_w = m_w - 1;
        end
        5: begin
          if (t1 && !t2) m_w = (m_w == m_d1) ? m_d0 : (m_w + 1) % 256;
          else if (t2 && !t1) m_w = (m_w == 0) ? m_d0 : m_w - 1;
        end
        6: if (t1) m_w = (m_w / 2) + (m_w % 2) * 128;
        7, 10: if (t1) m_w = (m_w / 2) + (t2 ? 128 : 0);
        default: ;
      endcase
    end
    m_f = nf;
  endfunction

  task automatic compare();
    bit exp_v = model_out();
    checks++;
    if (unit_out !== exp_v) begin
      errors++;
      $display("FAIL %s: unit_out=%0b expected=%0b (model reg=%0d)", tag, unit_out, exp_v, m_w);
    end
  endtask

  task automatic start(input string t, input int op, input int d0, input int d1);
    tag = t;
    @(negedge clk);
    rst_n = 1'b0;
    op_sel = 4'(op); load_val = 8'(d0); limit_val = 8'(d1);
    trig0 = 1'b0; trig1 = 1'b0; trig2 = 1'b0;
    m_op = op; m_d0 = d0; m_d1 = d1; m_w = 0; m_f = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    compare();
  endtask

  task automatic tick(input bit t0, input bit t1, input bit t2);
    trig0 = t0; trig1 = t1; trig2 = t2;
    @(posedge clk);
    model_step(t0, t1, t2);
    @(negedge clk);
    compare();
  endtask

  task automatic ticks(input int n, input bit t0, input bit t1, input bit t2);
    for (int i = 0; i < n; i++) tick(t0, t1, t2);
  endtask

  initial begin
    // R12: reset state and unused codes
    start("R12", 1, 9, 5);         // reg 0 -> one-shot down output high
    start("R12", 0, 9, 5);         // reg 0 != 5 -> low
    start("R12", 12, 7, 7);
    tick(1, 0, 0); ticks(3, 0, 1, 1);

    // R1: reload wins over stepping
    start("R1", 0, 3, 6);
    tick(1, 1, 1); tick(1, 1, 0); ticks(2, 0, 1, 0); tick(1, 0, 0);

    // R2: count up and stop at bound
    start("R2", 0, 3, 6);
    tick(1, 0, 0); ticks(6, 0, 1, 0); ticks(2, 0, 0, 0);
    start("R2", 0, 254, 1);        // crosses the top of the range
    tick(1, 0, 0); ticks(5, 0, 1, 0);

    // R3: count down and stop at zero
    start("R3", 1, 4, 9);
    tick(1, 0, 0); ticks(6, 0, 1, 0); tick(0, 0, 0);

    // R4: wrapping up-count, single-cycle pulse
    start("R4", 2, 2, 5);
    tick(1, 0, 0); ticks(10, 0, 1, 0);
    tick(1, 0, 0); ticks(3, 0, 1, 0); ticks(3, 0, 0, 0);

    // R5: wrapping down-count
    start("R5", 3, 3, 9);
    tick(1, 0, 0); ticks(9, 0, 1, 0); tick(0, 0, 0);
    tick(1, 0, 0); ticks(3, 0, 1, 0); ticks(2, 0, 0, 0);

    // R6: up/down clamped, both-high hold
    start("R6", 4, 1, 4);
    tick(1, 0, 0); ticks(5, 0, 1, 0); ticks(2, 0, 1, 1);
    ticks(6, 0, 0, 1); ticks(2, 0, 1, 1); tick(0, 1, 0);

    // R7: up/down wrapping
    start("R7", 5, 2, 4);
    tick(1, 0, 0); ticks(4, 0, 1, 0); tick(0, 1, 1);
    ticks(5, 0, 0, 1); ticks(2, 0, 1, 0);

    // R8: rotate right
    start("R8", 6, 8'hA5, 0);
    tick(1, 0, 0); ticks(9, 0, 1, 0); tick(0, 0, 1);
    start("R8", 6, 8'h01, 0);
    tick(1, 0, 0); ticks(9, 0, 1, 0);

    // R9: shift right with serial bit
    start("R9", 7, 8'h0F, 0);
    tick(1, 0, 0);
    for (int i = 0; i < 12; i++) tick(0, 1, bit'((i % 3) == 0));
    tick(0, 0, 1);

    // R10: compare operations
    start("R10", 8, 8'h0C, 8'h30); tick(1, 0, 0); ticks(2, 0, 1, 1);
    start("R10", 8, 8'h0C, 8'h04); tick(1, 0, 0); tick(0, 1, 0);
    start("R10", 9, 8'h00, 8'h00); tick(1, 0, 0); tick(0, 1, 1);
    start("R10", 9, 8'h00, 8'h80); tick(1, 0, 0);

    // R11: majority detect on a shifted stream
    start("R11", 10, 8'h00, 0);
    tick(1, 0, 0);
    for (int i = 0; i < 16; i++) tick(0, 1, bit'((i % 5) < 3));
    tick(1, 0, 0);
    start("R11", 10, 8'h06, 0); tick(1, 0, 0);
    start("R11", 10, 8'h0E, 0); tick(1, 0, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule